// File: doc/BRIEF.md
# I2C Status, Interrupt and DMA Request Unit

This unit holds the event side of a register-mapped I2C master controller: sticky status bits, an interrupt-enable mask, an interrupt vector and a small buffer-configuration word that picks which directions use DMA. The transfer engine reports events as single-cycle set pulses, and the ready bits are cleared by hardware pulses from the data path. The unit drives one level interrupt and two DMA request lines from the stored state.

Software reaches the unit through a simple register port with a 2-bit offset, write and read strobes and 16-bit data. Read data is registered and appears in the cycle after the read strobe. Reading the vector both reports and acknowledges the lowest pending enabled event. A revision parameter selects whether the enable mask is five or six bits wide.

Top module: `i2c_evt_unit`

## Requirements
- R1: After reset the status, enable and buffer-configuration words are zero, and the interrupt and both DMA request outputs are low.
- R2: The interrupt output, updated one cycle after the causing input, is high exactly when the stored status ANDed with the enable mask is nonzero.
- R3: A write to offset 0 (enable) keeps the low 6 bits when REV is at least REV_SPLIT, and the low 5 bits otherwise. A read of offset 0 returns the mask.
- R4: A write to offset 1 (status) clears only the stored bits where the written data is 1 within mask 0x0027, so NACK (bit 1) and access-ready (bit 2) clear. Receive-ready (bit 3) and transmit-ready (bit 4) are unaffected.
- R5: A read of offset 1 returns the stored status bits (1, 2, 3, 4, 10, 11, 15) with the live bus-busy input at bit 12.
- R6: A write to offset 3 (buffer configuration) keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable), and a read returns them.
- R7: The receive DMA request equals status bit 3 while bit 15 of the buffer word is set. The transmit DMA request equals status bit 4 while bit 7 is set. Each request is low when its enable is clear.
- R8: Writing offset 3 with bit 15 set clears enable bit 3, and writing it with bit 7 set clears enable bit 4. Other enable bits are unchanged.
- R9: A read of offset 2 returns one plus the position of the lowest set bit of status AND enable, or zero if none is set, and clears that status bit.
- R10: Bits of the event-set input set the matching stored status bits. A set wins over any clear in the same cycle. The two hardware ready-clear inputs clear bits 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_off_i | input | 2 | Register offset |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data, valid the cycle after the strobe |
| ev_set_i | input | 16 | Event set pulses, one per status bit position |
| rdy_clr_i | input | 2 | Hardware clear: bit 0 receive-ready, bit 1 transmit-ready |
| bus_busy_i | input | 1 | Live bus-busy indication |
| irq_o | output | 1 | Interrupt request |
| rx_drq_o | output | 1 | Receive DMA request |
| tx_drq_o | output | 1 | Transmit DMA request |

## Verification
The status word is driven with single events, with several events pending at once and with a set that collides with a software clear. A plain write clear is separated from a vector-read acknowledge, and both are separated from the hardware-only clear of the ready bits. Vector reads are repeated while more than one enabled bit is pending, which shows whether the lowest position is chosen first and only that bit is removed. A buffer write with all bits set is followed by ready events, which distinguishes a DMA request that follows status from a stale or ungated one, and checks that the matching interrupt enables were dropped.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int DATA_W = 16;
  localparam int OFF_W  = 2;

  typedef enum logic [OFF_W-1:0] {
    OFF_ENABLE = 2'd0,
    OFF_STATUS = 2'd1,
    OFF_VECTOR = 2'd2,
    OFF_BUFCFG = 2'd3
  } reg_off_e;

  localparam int B_NACK = 1;
  localparam int B_ARDY = 2;
  localparam int B_RRDY = 3;
  localparam int B_XRDY = 4;
  localparam int B_BUSY = 12;
  localparam int B_RDMA = 15;
  localparam int B_XDMA = 7;

  localparam logic [DATA_W-1:0] STORED_MASK = 16'h8C1E;
  localparam logic [DATA_W-1:0] SWCLR_MASK  = 16'h0027;
  localparam logic [DATA_W-1:0] BUFCFG_MASK = 16'h8080;
endpackage

// File: rtl/i2c_vec_enc.sv
module i2c_vec_enc #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  pend_i,
  output logic [CW-1:0] code_o
);
  always_comb begin
    code_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = CW'(i + 1);
    end
  end
endmodule

// File: rtl/i2c_stat_bank.sv
module i2c_stat_bank
  import i2c_evt_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] sw_clr_i,
  input  logic [W-1:0] ack_clr_i,
  input  logic [1:0]   rdy_clr_i,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] stat_n
);
  logic [W-1:0] hw_clr;

  always_comb begin
    hw_clr = '0;
    hw_clr[B_RRDY] = rdy_clr_i[0];
    hw_clr[B_XRDY] = rdy_clr_i[1];
    stat_n = ((stat_q & ~(sw_clr_i | ack_clr_i | hw_clr)) | set_i) & STORED_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_n;
  end

  // R4: the ready bits survive everything except a hardware or vector clear
  p_rrdy_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_q[B_RRDY] && !rdy_clr_i[0] && !ack_clr_i[B_RRDY]) |=> stat_q[B_RRDY]);
  p_xrdy_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_q[B_XRDY] && !rdy_clr_i[1] && !ack_clr_i[B_XRDY]) |=> stat_q[B_XRDY]);
  // R10: a set pulse always lands
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    set_i[B_NACK] |=> stat_q[B_NACK]);
endmodule

// File: rtl/i2c_evt_unit.sv
module i2c_evt_unit
  import i2c_evt_pkg::*;
#(
  parameter int REV       = 4,
  parameter int REV_SPLIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  reg_off_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [DATA_W-1:0] ev_set_i,
  input  logic [1:0]        rdy_clr_i,
  input  logic              bus_busy_i,
  output logic              irq_o,
  output logic              rx_drq_o,
  output logic              tx_drq_o
);
  localparam logic [DATA_W-1:0] EN_MASK = (REV >= REV_SPLIT) ? 16'h003F : 16'h001F;
  localparam int CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] stat_q, stat_n, sw_clr, ack_clr;
  logic [DATA_W-1:0] en_q, en_n, dma_q, dma_n, rd_n;
  logic [CW-1:0]     vec;
  logic wr_en, wr_st, wr_buf, rd_vec;

  assign wr_en  = reg_we_i && (reg_off_i == OFF_ENABLE);
  assign wr_st  = reg_we_i && (reg_off_i == OFF_STATUS);
  assign wr_buf = reg_we_i && (reg_off_i == OFF_BUFCFG);
  assign rd_vec = reg_re_i && (reg_off_i == OFF_VECTOR);

  i2c_vec_enc #(.W(DATA_W), .CW(CW)) u_enc (
    .pend_i (stat_q & en_q),
    .code_o (vec)
  );

  always_comb begin
    sw_clr  = wr_st ? (reg_wdata_i & SWCLR_MASK) : '0;
    ack_clr = '0;
    if (rd_vec && vec != '0) ack_clr[vec - CW'(1)] = 1'b1;
  end

  i2c_stat_bank #(.W(DATA_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .set_i     (ev_set_i),
    .sw_clr_i  (sw_clr),
    .ack_clr_i (ack_clr),
    .rdy_clr_i (rdy_clr_i),
    .stat_q    (stat_q),
    .stat_n    (stat_n)
  );

  always_comb begin
    en_n  = en_q;
    dma_n = dma_q;
    if (wr_en) en_n = reg_wdata_i & EN_MASK;
    if (wr_buf) begin
      dma_n = reg_wdata_i & BUFCFG_MASK;
      if (reg_wdata_i[B_RDMA]) en_n[B_RRDY] = 1'b0;
      if (reg_wdata_i[B_XDMA]) en_n[B_XRDY] = 1'b0;
    end
  end

  always_comb begin
    unique case (reg_off_i)
      OFF_ENABLE: rd_n = en_q;
      OFF_STATUS: rd_n = stat_q | (DATA_W'(bus_busy_i) << B_BUSY);
      OFF_VECTOR: rd_n = DATA_W'(vec);
      default:    rd_n = dma_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= '0;
      dma_q       <= '0;
      reg_rdata_o <= '0;
      irq_o       <= 1'b0;
      rx_drq_o    <= 1'b0;
      tx_drq_o    <= 1'b0;
    end else begin
      en_q     <= en_n;
      dma_q    <= dma_n;
      irq_o    <= |(stat_n & en_n);
      rx_drq_o <= dma_n[B_RDMA] & stat_n[B_RRDY];
      tx_drq_o <= dma_n[B_XDMA] & stat_n[B_XRDY];
      if (reg_re_i) reg_rdata_o <= rd_n;
    end
  end

  // R2: no interrupt without an enabled pending bit
  p_irq_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq_o);
  // R7: a DMA request only with its direction enabled and its ready bit set
  p_rx_drq_r7: assert property (@(posedge clk) disable iff (rst)
    rx_drq_o |-> (dma_q[B_RDMA] && stat_q[B_RRDY]));
  p_tx_drq_r7: assert property (@(posedge clk) disable iff (rst)
    tx_drq_o |-> (dma_q[B_XDMA] && stat_q[B_XRDY]));
  // R6: only the two DMA enables are ever held
  p_buf_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (dma_q & ~BUFCFG_MASK) == '0);
  // R8: a receive DMA enable write leaves the receive-ready enable off
  p_dma_drops_en_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_buf && reg_wdata_i[B_RDMA]) |=> !en_q[B_RRDY]);

  generate
    if (REV < REV_SPLIT) begin : g_old
      // R3: five-bit enable on the older revision
      p_en_width_r3: assert property (@(posedge clk) disable iff (rst)
        en_q[5] == 1'b0);
    end
  endgenerate
endmodule

// File: tb/i2c_evt_unit_test.sv
module i2c_evt_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  off = '0;
  logic        we = 1'b0, re = 1'b0, busy = 1'b0;
  logic [15:0] wdata = '0, evset = '0;
  logic [1:0]  rclr = '0;
  logic [15:0] rdata;
  logic        irq, rxd, txd;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state
  int m_stat = 0, m_en = 0, m_dma = 0, m_rd = 0;
  bit m_irq = 0, m_rx = 0, m_tx = 0;

  always #5 clk = ~clk;

  i2c_evt_unit uut (
    .clk(clk), .rst(rst), .reg_off_i(off), .reg_we_i(we), .reg_re_i(re),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ev_set_i(evset),
    .rdy_clr_i(rclr), .bus_busy_i(busy), .irq_o(irq), .rx_drq_o(rxd), .tx_drq_o(txd)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    int pend, vec, clr;
    if (rst) begin
      m_stat = 0; m_en = 0; m_dma = 0; m_rd = 0;
      m_irq = 0; m_rx = 0; m_tx = 0;
    end else begin
      pend = m_stat & m_en;
      vec = 0;
      for (int i = 15; i >= 0; i--) if ((pend >> i) & 1) vec = i + 1;
      if (re) begin
        case (off)
          2'd0: m_rd = m_en;
          2'd1: m_rd = m_stat | (busy ? 32'h1000 : 0);
          2'd2: m_rd = vec;
          default: m_rd = m_dma;
        endcase
      end
      clr = 0;
      if (we && off == 2'd1) clr = clr | (wdata & 32'h27);
      if (re && off == 2'd2 && vec != 0) clr = clr | (1 << (vec - 1));
      if (rclr[0]) clr = clr | 32'h8;
      if (rclr[1]) clr = clr | 32'h10;
      m_stat = ((m_stat & ~clr) | evset) & 32'h8C1E;
      if (we && off == 2'd0) m_en = wdata & 32'h3F;
      if (we && off == 2'd3) begin
        m_dma = wdata & 32'h8080;
        if (wdata[15]) m_en = m_en & ~32'h8;
        if (wdata[7])  m_en = m_en & ~32'h10;
      end
      m_irq = (m_stat & m_en) != 0;
      m_rx  = m_dma[15] && m_stat[3];
      m_tx  = m_dma[7] && m_stat[4];
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 irq", irq, m_irq);
      chk("R7 rx request", rxd, m_rx);
      chk("R7 tx request", txd, m_tx);
      chk("R5 R9 read data", rdata, m_rd);
    end
  end

  task automatic wr(logic [1:0] o, logic [15:0] d);
    @(negedge clk); off = o; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] o, output int v);
    @(negedge clk); off = o; re = 1'b1;
    @(negedge clk); re = 1'b0; v = rdata;
  endtask

  task automatic pulse(logic [15:0] s, logic [1:0] c);
    @(negedge clk); evset = s; rclr = c;
    @(negedge clk); evset = '0; rclr = '0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);
    chk("R1 drq after reset", rxd | txd, 0);
    rd(2'd1, v); chk("R1 status after reset", v, 0);
    rd(2'd0, v); chk("R1 enable after reset", v, 0);
    rd(2'd3, v); chk("R1 bufcfg after reset", v, 0);

    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R3 enable mask", v, 16'h003F);

    pulse(16'h0002, 2'b00);
    chk("R2 irq on nack", irq, 1);
    busy = 1'b1;
    rd(2'd1, v); chk("R5 status with busy", v, 16'h1002);
    busy = 1'b0;

    pulse(16'h0018, 2'b00);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, v); chk("R4 ready bits kept", v, 16'h0018);

    rd(2'd2, v); chk("R9 lowest vector", v, 4);
    rd(2'd2, v); chk("R9 next vector", v, 5);
    rd(2'd2, v); chk("R9 empty vector", v, 0);
    chk("R2 irq idle", irq, 0);

    pulse(16'h8C00, 2'b00);
    rd(2'd1, v); chk("R10 high bits set", v, 16'h8C00);
    rd(2'd2, v); chk("R9 no enabled bit", v, 0);

    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); chk("R6 bufcfg mask", v, 16'h8080);
    rd(2'd0, v); chk("R8 enables dropped", v, 16'h0027);
    pulse(16'h0008, 2'b00);
    chk("R7 rx request up", rxd, 1);
    chk("R8 no irq from dma ready", irq, 0);
    pulse(16'h0010, 2'b01);
    chk("R10 hw clear rx", rxd, 0);
    chk("R7 tx request up", txd, 1);
    pulse(16'h0000, 2'b10);
    chk("R7 tx request down", txd, 0);

    // set collides with a software clear
    @(negedge clk); off = 2'd1; wdata = 16'h0004; we = 1'b1; evset = 16'h0004;
    @(negedge clk); we = 1'b0; evset = '0;
    rd(2'd1, v); chk("R10 set wins", v & 16'h0004, 16'h0004);
    chk("R2 irq from ardy", irq, 1);

    wr(2'd3, 16'h0000);
    pulse(16'h0008, 2'b00);
    chk("R7 rx request gated", rxd, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule